// File: doc/BRIEF.md
# Windowed Service Watchdog with One-Shot Configuration

This block is a 32-bit down-counting watchdog that software must service inside a permitted window. A service is a two-word key sequence written to one register address. If the service arrives while the count is still above the programmed window value, or the key words are wrong, or the count runs down to zero, the block raises a reset request and records the cause. The request and the cause stay set until the block is reset.

The count advances on one of three tick strobes. Each strobe is a single-cycle pulse, already synchronised to `clk`, that marks an edge of the fast internal RC clock, the slow internal RC clock or the main clock. Software first writes the timeout and the window values. It then writes the control register, which selects the tick source, locks the whole configuration and starts the count from the timeout value. From that write until the next reset, configuration writes have no effect. The counter stays idle until the control write arrives.

A simple register port gives the system access: a write strobe with address and data, and a separate read address with combinational read data.

Top module: `wdog_window_lock`

## Requirements
- R1: After reset, `rst_req` is 0, `fault_cause` is 0, and every readable register reads 0: timeout (address 0), window (address 1), control/status (address 2) and count (address 3).
- R2: Before the control write, writes to address 0 and address 1 load the timeout and window values, and those values read back. Tick pulses leave the count at 0. Key writes to address 3 raise no fault.
- R3: The first write to address 2 locks the configuration and takes the tick source from data bits [1:0]. On the next cycle, address 2 reads the source in bits [1:0] with bit 2 (locked) set, and the count reads the timeout value.
- R4: Once locked, writes to addresses 0, 1 and 2 change neither the stored values nor the count.
- R5: While running, each pulse on the selected tick input decrements the count by one, and pulses on the other inputs have no effect. The source codes are: 0 selects the fast RC tick, 1 the slow RC tick, 2 the main-clock tick and 3 the fast RC tick.
- R6: A service is KEY_A (default 32'hC3D2_E1F0) followed by KEY_B (default 32'h3C2D_1E0F), written in order to address 3. When the second word is accepted while 0 < count <= window, the count reloads to the timeout and no fault occurs. The boundary count == window is accepted.
- R7: When a correct key sequence completes while the count is above the window value (including window + 1), an early fault occurs: `rst_req` goes to 1, `fault_cause` bit 0 is set, and bit 3 of address 2 is set.
- R8: While running, a write to address 3 that is not the expected next key word is an invalid-key fault, whether it is the first word or the second. `rst_req` goes to 1, `fault_cause` bit 1 is set, and bit 4 of address 2 is set.
- R9: A selected tick that arrives while the count is 1 drives the count to 0 and causes a timeout fault. `rst_req` goes to 1, `fault_cause` bit 2 is set, and bit 5 of address 2 is set.
- R10: After any fault, `rst_req` and the cause bits hold until reset, only one cause bit is ever set, the count freezes, and further key writes and ticks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_fast | input | 1 | Count strobe from the fast internal RC domain |
| tick_slow | input | 1 | Count strobe from the slow internal RC domain |
| tick_main | input | 1 | Count strobe from the main clock domain |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 timeout, 1 window, 2 control, 3 service key |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address: 0 timeout, 1 window, 2 control/status, 3 count |
| rd_data | output | 32 | Combinational read data |
| rst_req | output | 1 | Reset request, sticky until reset |
| fault_cause | output | 3 | Bit 0 early, bit 1 invalid key, bit 2 timeout |

## Verification
The bench services at exactly count == window, which must be accepted, and at window + 1, which must fault. A design with an off-by-one window compare fails one of the two. It repeats the first key word and also writes a wrong first word; a design that checks only one position of the sequence misses one of these invalid-key faults. It writes the configuration again after the lock and pulses the unselected ticks. A design that leaks either one shows a changed register value or count. After each fault it keeps ticking and servicing, so a design that keeps counting or clears the cause is caught.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int SRC_W   = 2;
    localparam int CAUSE_W = 3;

    localparam logic [1:0] ADDR_TMO  = 2'd0;
    localparam logic [1:0] ADDR_WIN  = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;
    localparam logic [1:0] ADDR_KEY  = 2'd3;

    localparam int CAUSE_EARLY = 0;
    localparam int CAUSE_KEY   = 1;
    localparam int CAUSE_TMO   = 2;
endpackage

// File: rtl/wdog_tick_sel.sv
module wdog_tick_sel #(
    parameter int N_SRC = 3,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] tick_in,
    input  logic [SEL_W-1:0] sel,
    output logic             tick_o
);
    logic [N_SRC-1:0] hit;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            if (g == 0) begin : g_dflt
                assign hit[g] = tick_in[g] && ((int'(sel) == 0) || (int'(sel) >= N_SRC));
            end else begin : g_pick
                assign hit[g] = tick_in[g] && (int'(sel) == g);
            end
        end
    endgenerate

    assign tick_o = |hit;

    // R5: never more than one source may be routed through
    always_comb begin
        p_single_src_r5: assert ($onehot0(hit));
    end
endmodule

// File: rtl/wdog_cfg.sv
module wdog_cfg
    import wdog_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] tmo_o,
    output logic [CNT_W-1:0] win_o,
    output logic [SRC_W-1:0] src_o,
    output logic             locked_o,
    output logic             start_o
);
    typedef struct packed {
        logic [CNT_W-1:0] tmo;
        logic [CNT_W-1:0] win;
        logic [SRC_W-1:0] src;
        logic             locked;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic start_d;

    always_comb begin
        cfg_d   = cfg_q;
        start_d = 1'b0;
        if (wr_en && !cfg_q.locked) begin
            unique case (wr_addr)
                ADDR_TMO:  cfg_d.tmo = wr_data;
                ADDR_WIN:  cfg_d.win = wr_data;
                ADDR_CTRL: begin
                    cfg_d.src    = wr_data[SRC_W-1:0];
                    cfg_d.locked = 1'b1;
                    start_d      = 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign tmo_o    = cfg_q.tmo;
    assign win_o    = cfg_q.win;
    assign src_o    = cfg_q.src;
    assign locked_o = cfg_q.locked;
    assign start_o  = start_d;

    p_lock_on_ctrl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_CTRL) |=> locked_o);

    p_cfg_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |=> (locked_o && $stable(tmo_o) && $stable(win_o) && $stable(src_o)));
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int               CNT_W = 32,
    parameter logic [CNT_W-1:0] KEY_A = 32'hC3D2_E1F0,
    parameter logic [CNT_W-1:0] KEY_B = 32'h3C2D_1E0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               tick,
    input  logic               key_wr,
    input  logic [CNT_W-1:0]   key_data,
    input  logic [CNT_W-1:0]   tmo,
    input  logic [CNT_W-1:0]   win,
    output logic [CNT_W-1:0]   count_o,
    output logic [CAUSE_W-1:0] cause_o
);
    typedef struct packed {
        logic [CNT_W-1:0]   count;
        logic               armed;
        logic               running;
        logic [CAUSE_W-1:0] cause;
    } core_t;

    core_t st_d, st_q;
    logic  faulted;

    assign faulted = |st_q.cause;

    always_comb begin
        st_d = st_q;
        if (!st_q.running) begin
            if (start) begin
                st_d.count   = tmo;
                st_d.running = 1'b1;
            end
        end else if (!faulted) begin
            if (key_wr) begin
                if (!st_q.armed) begin
                    if (key_data == KEY_A) st_d.armed = 1'b1;
                    else                   st_d.cause[CAUSE_KEY] = 1'b1;
                end else begin
                    st_d.armed = 1'b0;
                    if (key_data != KEY_B)     st_d.cause[CAUSE_KEY]   = 1'b1;
                    else if (st_q.count > win) st_d.cause[CAUSE_EARLY] = 1'b1;
                    else                       st_d.count = tmo;
                end
            end else if (tick) begin
                if (st_q.count <= CNT_W'(1)) begin
                    st_d.count            = '0;
                    st_d.cause[CAUSE_TMO] = 1'b1;
                end else begin
                    st_d.count = st_q.count - CNT_W'(1);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_o = st_q.count;
    assign cause_o = st_q.cause;

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && !start) |=> (count_o == '0 && cause_o == '0));

    p_start_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.running && start) |=> (count_o == $past(tmo)));

    p_cause_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        faulted |=> (cause_o == $past(cause_o) && $stable(count_o)));

    p_single_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));

    p_timeout_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cause_o[CAUSE_TMO]) |-> (count_o == '0));
endmodule

// File: rtl/wdog_window_lock.sv
module wdog_window_lock
    import wdog_pkg::*;
#(
    parameter int          CNT_W = 32,
    parameter logic [31:0] KEY_A = 32'hC3D2_E1F0,
    parameter logic [31:0] KEY_B = 32'h3C2D_1E0F
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick_fast,
    input  logic               tick_slow,
    input  logic               tick_main,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    input  logic [1:0]         rd_addr,
    output logic [CNT_W-1:0]   rd_data,
    output logic               rst_req,
    output logic [CAUSE_W-1:0] fault_cause
);
    localparam int N_SRC = 3;

    logic [CNT_W-1:0]   tmo, win, count;
    logic [SRC_W-1:0]   src;
    logic               locked, start, tick, key_wr;
    logic [CAUSE_W-1:0] cause;

    assign key_wr = wr_en && (wr_addr == ADDR_KEY);

    wdog_cfg #(.CNT_W(CNT_W)) i_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tmo_o    (tmo),
        .win_o    (win),
        .src_o    (src),
        .locked_o (locked),
        .start_o  (start)
    );

    wdog_tick_sel #(.N_SRC(N_SRC), .SEL_W(SRC_W)) i_tick (
        .tick_in ({tick_main, tick_slow, tick_fast}),
        .sel     (src),
        .tick_o  (tick)
    );

    wdog_core #(.CNT_W(CNT_W), .KEY_A(CNT_W'(KEY_A)), .KEY_B(CNT_W'(KEY_B))) i_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tick     (tick),
        .key_wr   (key_wr),
        .key_data (wr_data),
        .tmo      (tmo),
        .win      (win),
        .count_o  (count),
        .cause_o  (cause)
    );

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_TMO:  rd_data = tmo;
            ADDR_WIN:  rd_data = win;
            ADDR_CTRL: begin
                rd_data[SRC_W-1:0]               = src;
                rd_data[SRC_W]                   = locked;
                rd_data[SRC_W+CAUSE_W:SRC_W+1]   = cause;
            end
            default:   rd_data = count;
        endcase
    end

    assign rst_req     = |cause;
    assign fault_cause = cause;

    p_req_needs_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> locked);
endmodule

// File: tb/test_wdog_window_lock.sv
module test_wdog_window_lock;
    localparam logic [31:0] KA = 32'hC3D2_E1F0;
    localparam logic [31:0] KB = 32'h3C2D_1E0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_fast = 1'b0, tick_slow = 1'b0, tick_main = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        rst_req;
    logic [2:0]  fault_cause;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    wdog_window_lock i_wdog_window_lock (
        .clk(clk), .rst_n(rst_n),
        .tick_fast(tick_fast), .tick_slow(tick_slow), .tick_main(tick_main),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .rst_req(rst_req), .fault_cause(fault_cause)
    );

    typedef struct {
        string       tag;
        logic [1:0]  addr;
        logic [31:0] rd;
        logic        rst;
        logic [2:0]  cause;
    } exp_t;

    exp_t sb[$];

    // monitor: pops expected items and compares, sampling mid-cycle
    initial begin
        forever begin
            wait (sb.size() != 0);
            #3;
            rd_addr = sb[0].addr;
            #1;
            n_chk += 3;
            if (rd_data !== sb[0].rd) begin
                n_fail++;
                $display("FAIL %s: rd_data[addr %0d] actual %0d expected %0d",
                         sb[0].tag, sb[0].addr, rd_data, sb[0].rd);
            end
            if (rst_req !== sb[0].rst) begin
                n_fail++;
                $display("FAIL %s: rst_req actual %0b expected %0b", sb[0].tag, rst_req, sb[0].rst);
            end
            if (fault_cause !== sb[0].cause) begin
                n_fail++;
                $display("FAIL %s: fault_cause actual %03b expected %03b",
                         sb[0].tag, fault_cause, sb[0].cause);
            end
            void'(sb.pop_front());
        end
    end

    task automatic expect_state(input string tag, input logic [1:0] a, input logic [31:0] rd,
                                input logic rst, input logic [2:0] cause);
        exp_t e;
        e.tag = tag; e.addr = a; e.rd = rd; e.rst = rst; e.cause = cause;
        sb.push_back(e);
        wait (sb.size() == 0);
    endtask

    // tk bits: [0] fast, [1] slow, [2] main
    task automatic cyc(input logic we, input logic [1:0] a, input logic [31:0] d, input logic [2:0] tk);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d;
        {tick_main, tick_slow, tick_fast} = tk;
        @(negedge clk);
        wr_en = 1'b0;
        {tick_main, tick_slow, tick_fast} = 3'b000;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 3'b000);
    endtask

    task automatic ticks(input logic [2:0] tk, input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 2'd0, 32'd0, tk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        expect_state("R1 timeout reg", 2'd0, 32'd0, 1'b0, 3'b000);
        expect_state("R1 ctrl reg",    2'd2, 32'd0, 1'b0, 3'b000);
        expect_state("R1 count",       2'd3, 32'd0, 1'b0, 3'b000);

        // R2 pre-lock writes and idle counter
        wr(2'd0, 32'd20);
        wr(2'd1, 32'd8);
        expect_state("R2 timeout readback", 2'd0, 32'd20, 1'b0, 3'b000);
        expect_state("R2 window readback",  2'd1, 32'd8,  1'b0, 3'b000);
        ticks(3'b111, 3);
        wr(2'd3, 32'h1234);
        wr(2'd3, KA);
        wr(2'd3, KB);
        expect_state("R2 idle count, no fault", 2'd3, 32'd0, 1'b0, 3'b000);

        // R3 lock with slow source
        wr(2'd2, 32'd1);
        expect_state("R3 ctrl locked src1", 2'd2, 32'd5,  1'b0, 3'b000);
        expect_state("R3 count loaded",     2'd3, 32'd20, 1'b0, 3'b000);

        // R4 writes after lock ignored
        wr(2'd0, 32'd99);
        wr(2'd1, 32'd1);
        wr(2'd2, 32'd2);
        expect_state("R4 timeout kept", 2'd0, 32'd20, 1'b0, 3'b000);
        expect_state("R4 window kept",  2'd1, 32'd8,  1'b0, 3'b000);
        expect_state("R4 ctrl kept",    2'd2, 32'd5,  1'b0, 3'b000);
        expect_state("R4 count kept",   2'd3, 32'd20, 1'b0, 3'b000);

        // R5 only the selected tick counts
        ticks(3'b101, 2);
        expect_state("R5 unselected ticks", 2'd3, 32'd20, 1'b0, 3'b000);
        ticks(3'b010, 3);
        expect_state("R5 slow ticks", 2'd3, 32'd17, 1'b0, 3'b000);

        // R6 service at count == window
        ticks(3'b010, 9);
        expect_state("R6 at window", 2'd3, 32'd8, 1'b0, 3'b000);
        wr(2'd3, KA);
        wr(2'd3, KB);
        expect_state("R6 reload", 2'd3, 32'd20, 1'b0, 3'b000);

        // R7 service at window + 1
        ticks(3'b010, 11);
        wr(2'd3, KA);
        expect_state("R7 first key no fault", 2'd3, 32'd9, 1'b0, 3'b000);
        wr(2'd3, KB);
        expect_state("R7 early fault", 2'd2, 32'd13, 1'b1, 3'b001);

        // R10 sticky and frozen
        ticks(3'b111, 2);
        wr(2'd3, KA);
        wr(2'd3, KB);
        expect_state("R10 count frozen", 2'd3, 32'd9, 1'b1, 3'b001);

        // R8 second word wrong
        do_reset();
        expect_state("R1 after reset", 2'd3, 32'd0, 1'b0, 3'b000);
        wr(2'd0, 32'd5);
        wr(2'd1, 32'd5);
        wr(2'd2, 32'd2);
        expect_state("R3 ctrl src2", 2'd2, 32'd6, 1'b0, 3'b000);
        ticks(3'b001, 1);
        ticks(3'b100, 1);
        expect_state("R5 main tick", 2'd3, 32'd4, 1'b0, 3'b000);
        wr(2'd3, KA);
        wr(2'd3, KA);
        expect_state("R8 bad second word", 2'd2, 32'd22, 1'b1, 3'b010);
        expect_state("R10 count frozen key", 2'd3, 32'd4, 1'b1, 3'b010);

        // R8 first word wrong
        do_reset();
        wr(2'd0, 32'd7);
        wr(2'd1, 32'd7);
        wr(2'd2, 32'd0);
        wr(2'd3, KB);
        expect_state("R8 bad first word", 2'd2, 32'd20, 1'b1, 3'b010);

        // R9 timeout with source code 3 (fast)
        do_reset();
        wr(2'd0, 32'd3);
        wr(2'd1, 32'd3);
        wr(2'd2, 32'd3);
        ticks(3'b110, 2);
        expect_state("R5 src3 ignores slow/main", 2'd3, 32'd3, 1'b0, 3'b000);
        ticks(3'b001, 2);
        expect_state("R9 count at one", 2'd3, 32'd1, 1'b0, 3'b000);
        ticks(3'b001, 1);
        expect_state("R9 timeout count", 2'd3, 32'd0, 1'b1, 3'b100);
        expect_state("R9 timeout status", 2'd2, 32'd39, 1'b1, 3'b100);
        wr(2'd3, KA);
        wr(2'd3, KB);
        expect_state("R10 service after timeout ignored", 2'd2, 32'd39, 1'b1, 3'b100);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule